// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Load Interlock

This block sits at the decode stage of a 32-bit, five-stage, in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it receives the two source register indices of the instruction in decode, the values read from the register file for those indices, and a description of the three instructions ahead of it: the one in execute (slot 0, youngest), the one in memory (slot 1) and the one in writeback (slot 2). Each slot gives a destination index, a valid bit, a write-enable, a load flag and its result value. The memory slot's value is the load data when that instruction is a load.

Each operand is corrected on its own. The youngest older instruction that writes the source register supplies the value, and the register file value is used only when no slot matches. Instructions four or more places ahead are not examined, because their writeback has finished before decode reads the file. Dependent arithmetic back to back needs no stall. A load's data exists only after the memory stage, so a consumer directly behind a load stalls for one cycle, while a consumer two places behind takes the data from the memory slot with no stall. Stores and branches drive their write-enable low and can never match.

The block also holds the operand registers at the decode-to-execute boundary. On a stall it loads a bubble into execute and keeps the operands, and the pipeline control uses the stall output to hold fetch and decode.

Top module: `raw_bypass_unit`

## Requirements
- R1: For each operand, when more than one slot matches the source index, the value comes from the lowest-numbered (youngest) matching slot: slot 0 before slot 1 before slot 2.
- R2: When no slot matches a source index, that operand equals its register file read value.
- R3: A slot with its valid bit or its write-enable low never supplies a value and never causes a stall.
- R4: The two operands are selected independently, so operand A may come from one slot while operand B comes from a different slot in the same cycle.
- R5: `stall_req` is high exactly when decode is valid and slot 0 is a valid, writing load whose destination equals a source that is in use. A load in slot 1 or slot 2 forwards its value with `stall_req` low.
- R6: A source whose use flag is low never causes a stall.
- R7: After a cycle with `stall_req` high, `ex_vld` is 0 (a bubble) and `ex_opa`/`ex_opb` keep their previous values.
- R8: After a cycle with `dec_vld` high and `stall_req` low, `ex_vld` is 1 and `ex_opa`/`ex_opb` equal the `byp_a`/`byp_b` values of that cycle.
- R9: While `rst_n` is low, `ex_vld`, `ex_opa` and `ex_opb` are 0.
- R10: When `dec_vld` is low, `stall_req` is low and `ex_vld` is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_vld | input | 1 | Decode stage holds a real instruction |
| dec_src_a | input | IW | Source index of operand A |
| dec_src_b | input | IW | Source index of operand B |
| dec_use_a | input | 1 | Operand A is read by the instruction |
| dec_use_b | input | 1 | Operand B is read by the instruction |
| rf_rd_a | input | DW | Register file value for operand A |
| rf_rd_b | input | DW | Register file value for operand B |
| prd_dst | input | NP*IW | Destination index per slot, slot k at bits [k*IW +: IW] |
| prd_vld | input | NP | Slot holds a real instruction |
| prd_wen | input | NP | Slot writes its destination |
| prd_ld | input | NP | Slot is a load |
| prd_val | input | NP*DW | Result per slot, slot k at bits [k*DW +: DW] |
| byp_a | output | DW | Corrected operand A (combinational) |
| byp_b | output | DW | Corrected operand B (combinational) |
| stall_req | output | 1 | Load-use interlock: hold fetch and decode this cycle |
| ex_vld | output | 1 | Execute stage valid (0 for a bubble) |
| ex_opa | output | DW | Registered operand A for execute |
| ex_opb | output | DW | Registered operand B for execute |

## Verification
`byp_a`, `byp_b` and `stall_req` are pure functions of the present inputs, so the bench samples them 1 ns after driving each vector on the falling edge, in the same cycle. The execute-stage registers change at the next rising edge, and the bench reads them 1 ns after that edge, comparing them with a value it computed from the previous vector's expected operands and stall. A sweep over all combinations of four register indices across both sources and the three slots, with random valid, write and load flags, exercises every priority case, each alongside random register file and result values.

// File: rtl/raw_byp_pkg.sv
package raw_byp_pkg;
  localparam int unsigned DEF_IW = 5;
  localparam int unsigned DEF_DW = 32;
  localparam int unsigned DEF_NP = 3;
  localparam int unsigned NUM_OPND = 2;
  localparam int unsigned STALL_SLOT = 0;
endpackage

// File: rtl/rbu_match.sv
module rbu_match #(
  parameter int unsigned IW = raw_byp_pkg::DEF_IW,
  parameter int unsigned NP = raw_byp_pkg::DEF_NP
) (
  input  logic [IW-1:0]    src,
  input  logic [NP*IW-1:0] dst,
  input  logic [NP-1:0]    vld,
  input  logic [NP-1:0]    wen,
  output logic [NP-1:0]    hit
);
  for (genvar k = 0; k < NP; k++) begin : g_slot
    assign hit[k] = vld[k] & wen[k] & (dst[k*IW +: IW] == src);
  end
endmodule

// File: rtl/rbu_pick.sv
module rbu_pick #(
  parameter int unsigned DW = raw_byp_pkg::DEF_DW,
  parameter int unsigned NP = raw_byp_pkg::DEF_NP
) (
  input  logic [NP-1:0]    hit,
  input  logic [NP*DW-1:0] val,
  input  logic [DW-1:0]    rf,
  output logic [DW-1:0]    opnd
);
  // oldest first, so a younger hit overrides
  always_comb begin
    opnd = rf;
    for (int k = NP - 1; k >= 0; k--) begin
      if (hit[k]) opnd = val[k*DW +: DW];
    end
  end
endmodule

// File: rtl/raw_bypass_unit.sv
module raw_bypass_unit #(
  parameter int unsigned IW = raw_byp_pkg::DEF_IW,
  parameter int unsigned DW = raw_byp_pkg::DEF_DW,
  parameter int unsigned NP = raw_byp_pkg::DEF_NP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_vld,
  input  logic [IW-1:0]    dec_src_a,
  input  logic [IW-1:0]    dec_src_b,
  input  logic             dec_use_a,
  input  logic             dec_use_b,
  input  logic [DW-1:0]    rf_rd_a,
  input  logic [DW-1:0]    rf_rd_b,
  input  logic [NP*IW-1:0] prd_dst,
  input  logic [NP-1:0]    prd_vld,
  input  logic [NP-1:0]    prd_wen,
  input  logic [NP-1:0]    prd_ld,
  input  logic [NP*DW-1:0] prd_val,
  output logic [DW-1:0]    byp_a,
  output logic [DW-1:0]    byp_b,
  output logic             stall_req,
  output logic             ex_vld,
  output logic [DW-1:0]    ex_opa,
  output logic [DW-1:0]    ex_opb
);
  localparam int unsigned NO = raw_byp_pkg::NUM_OPND;
  localparam int unsigned SS = raw_byp_pkg::STALL_SLOT;

  logic [IW-1:0] src_v [NO];
  logic [DW-1:0] rf_v  [NO];
  logic [DW-1:0] byp_v [NO];
  logic [NP-1:0] hit_v [NO];
  logic [NO-1:0] use_v;
  logic [NO-1:0] ld_hazard;

  assign src_v[0] = dec_src_a;
  assign src_v[1] = dec_src_b;
  assign rf_v[0]  = rf_rd_a;
  assign rf_v[1]  = rf_rd_b;
  assign use_v    = {dec_use_b, dec_use_a};

  for (genvar o = 0; o < NO; o++) begin : g_opnd
    rbu_match #(.IW(IW), .NP(NP)) u_match (
      .src (src_v[o]),
      .dst (prd_dst),
      .vld (prd_vld),
      .wen (prd_wen),
      .hit (hit_v[o])
    );
    rbu_pick #(.DW(DW), .NP(NP)) u_pick (
      .hit  (hit_v[o]),
      .val  (prd_val),
      .rf   (rf_v[o]),
      .opnd (byp_v[o])
    );
    assign ld_hazard[o] = use_v[o] & hit_v[o][SS] & prd_ld[SS];
  end

  assign byp_a     = byp_v[0];
  assign byp_b     = byp_v[1];
  assign stall_req = dec_vld & (|ld_hazard);

  // decode-to-execute boundary registers
  logic          adv_en;
  logic          ex_vld_d;
  logic [DW-1:0] ex_opa_d;
  logic [DW-1:0] ex_opb_d;

  assign adv_en = dec_vld & ~stall_req;

  always_comb begin
    ex_vld_d = adv_en;
    ex_opa_d = ex_opa;
    ex_opb_d = ex_opb;
    if (adv_en) begin
      ex_opa_d = byp_a;
      ex_opb_d = byp_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_vld <= 1'b0;
      ex_opa <= '0;
      ex_opb <= '0;
    end else begin
      ex_vld <= ex_vld_d;
      ex_opa <= ex_opa_d;
      ex_opb <= ex_opb_d;
    end
  end
endmodule

// File: rtl/raw_bypass_unit_chk.sv
module raw_bypass_unit_chk #(
  parameter int unsigned IW = raw_byp_pkg::DEF_IW,
  parameter int unsigned DW = raw_byp_pkg::DEF_DW,
  parameter int unsigned NP = raw_byp_pkg::DEF_NP
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_vld,
  input logic [DW-1:0]    rf_rd_a,
  input logic [DW-1:0]    rf_rd_b,
  input logic [NP-1:0]    prd_vld,
  input logic [NP-1:0]    prd_wen,
  input logic [NP-1:0]    prd_ld,
  input logic [DW-1:0]    byp_a,
  input logic [DW-1:0]    byp_b,
  input logic             stall_req,
  input logic             ex_vld,
  input logic [DW-1:0]    ex_opa,
  input logic [DW-1:0]    ex_opb
);
  // R7
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> !ex_vld);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> ($stable(ex_opa) && $stable(ex_opb)));
  // R8
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !stall_req) |=> (ex_vld && ex_opa == $past(byp_a) && ex_opb == $past(byp_b)));
  // R10
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> !stall_req);
  // R5
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> (prd_ld[0] && prd_wen[0] && prd_vld[0]));
  // R3
  no_writer_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((prd_vld & prd_wen) == '0) |-> (byp_a == rf_rd_a && byp_b == rf_rd_b && !stall_req));
endmodule

bind raw_bypass_unit raw_bypass_unit_chk #(.IW(IW), .DW(DW), .NP(NP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_vld   (dec_vld),
  .rf_rd_a   (rf_rd_a),
  .rf_rd_b   (rf_rd_b),
  .prd_vld   (prd_vld),
  .prd_wen   (prd_wen),
  .prd_ld    (prd_ld),
  .byp_a     (byp_a),
  .byp_b     (byp_b),
  .stall_req (stall_req),
  .ex_vld    (ex_vld),
  .ex_opa    (ex_opa),
  .ex_opb    (ex_opb)
);

// File: tb/raw_bypass_unit_test.sv
`timescale 1ns/1ps
module raw_bypass_unit_test;
  localparam int IW = 5;
  localparam int DW = 32;
  localparam int NP = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             dec_vld, dec_use_a, dec_use_b;
  logic [IW-1:0]    dec_src_a, dec_src_b;
  logic [DW-1:0]    rf_rd_a, rf_rd_b;
  logic [NP*IW-1:0] prd_dst;
  logic [NP-1:0]    prd_vld, prd_wen, prd_ld;
  logic [NP*DW-1:0] prd_val;
  logic [DW-1:0]    byp_a, byp_b, ex_opa, ex_opb;
  logic             stall_req, ex_vld;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] m_opa, m_opb;

  raw_bypass_unit #(.IW(IW), .DW(DW), .NP(NP)) uut (
    .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_use_a(dec_use_a), .dec_use_b(dec_use_b),
    .rf_rd_a(rf_rd_a), .rf_rd_b(rf_rd_b),
    .prd_dst(prd_dst), .prd_vld(prd_vld), .prd_wen(prd_wen),
    .prd_ld(prd_ld), .prd_val(prd_val),
    .byp_a(byp_a), .byp_b(byp_b), .stall_req(stall_req),
    .ex_vld(ex_vld), .ex_opa(ex_opa), .ex_opb(ex_opb)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: youngest writing valid slot wins, else register file
  function automatic logic [DW-1:0] ref_opnd(input logic [IW-1:0] s, input logic [DW-1:0] rf);
    for (int k = 0; k < NP; k++)
      if (prd_vld[k] && prd_wen[k] && prd_dst[k*IW +: IW] == s) return prd_val[k*DW +: DW];
    return rf;
  endfunction

  function automatic logic ref_stall();
    logic d0;
    d0 = prd_vld[0] && prd_wen[0] && prd_ld[0];
    return dec_vld && d0 &&
      ((dec_use_a && prd_dst[IW-1:0] == dec_src_a) || (dec_use_b && prd_dst[IW-1:0] == dec_src_b));
  endfunction

  task automatic drive(input logic dv, input logic [IW-1:0] sa, input logic [IW-1:0] sb,
                       input logic ua, input logic ub, input logic [NP*IW-1:0] dst,
                       input logic [NP-1:0] v, input logic [NP-1:0] w, input logic [NP-1:0] l);
    @(negedge clk);
    dec_vld = dv; dec_src_a = sa; dec_src_b = sb; dec_use_a = ua; dec_use_b = ub;
    prd_dst = dst; prd_vld = v; prd_wen = w; prd_ld = l;
    rf_rd_a = $urandom; rf_rd_b = $urandom;
    for (int k = 0; k < NP; k++) prd_val[k*DW +: DW] = {4'(k + 1), 28'($urandom)};
    #1;
  endtask

  // sample registers after the edge that follows the current vector
  task automatic step_regs(input string tag);
    logic adv;
    logic [DW-1:0] ea, eb;
    adv = dec_vld && !ref_stall();
    ea = ref_opnd(dec_src_a, rf_rd_a);
    eb = ref_opnd(dec_src_b, rf_rd_b);
    @(posedge clk); #1;
    if (adv) begin m_opa = ea; m_opb = eb; end
    chk(ex_vld == adv, {tag, " ex_vld"}, DW'(ex_vld), DW'(adv));
    chk(ex_opa == m_opa, {tag, " ex_opa"}, ex_opa, m_opa);
    chk(ex_opb == m_opb, {tag, " ex_opb"}, ex_opb, m_opb);
  endtask

  task automatic check_comb(input string tag);
    logic [DW-1:0] ea, eb;
    ea = ref_opnd(dec_src_a, rf_rd_a);
    eb = ref_opnd(dec_src_b, rf_rd_b);
    chk(byp_a == ea, {tag, " byp_a"}, byp_a, ea);
    chk(byp_b == eb, {tag, " byp_b"}, byp_b, eb);
    chk(stall_req == ref_stall(), "R5 stall_req", DW'(stall_req), DW'(ref_stall()));
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    dec_vld = 0; dec_use_a = 0; dec_use_b = 0; dec_src_a = '0; dec_src_b = '0;
    rf_rd_a = '0; rf_rd_b = '0; prd_dst = '0; prd_vld = '0; prd_wen = '0; prd_ld = '0; prd_val = '0;
    m_opa = '0; m_opb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(ex_vld == 1'b0, "R9 ex_vld", DW'(ex_vld), '0);
    chk(ex_opa == '0, "R9 ex_opa", ex_opa, '0);
    chk(ex_opb == '0, "R9 ex_opb", ex_opb, '0);
    rst_n = 1'b1;

    // R2 no slot matches: register file values
    drive(1, 5'd7, 5'd8, 1, 1, {5'd1, 5'd2, 5'd3}, 3'b111, 3'b111, 3'b000);
    check_comb("R2");
    chk(byp_a == rf_rd_a, "R2 rf pass", byp_a, rf_rd_a);
    step_regs("R8");

    // R3 matching slot with write-enable low, and one with valid low
    drive(1, 5'd4, 5'd4, 1, 1, {5'd9, 5'd4, 5'd4}, 3'b101, 3'b110, 3'b001);
    chk(byp_a == rf_rd_a, "R3 disabled slots", byp_a, rf_rd_a);
    chk(stall_req == 1'b0, "R3 no stall", DW'(stall_req), '0);
    step_regs("R8");

    // R4 A from slot 0, B from slot 1; R1 slot 0 beats slot 2 on A
    drive(1, 5'd3, 5'd6, 1, 1, {5'd3, 5'd6, 5'd3}, 3'b111, 3'b111, 3'b000);
    chk(byp_a == prd_val[DW-1:0], "R4 a from slot0", byp_a, prd_val[DW-1:0]);
    chk(byp_b == prd_val[DW +: DW], "R4 b from slot1", byp_b, prd_val[DW +: DW]);
    step_regs("R8");

    // R5 load in slot 1 forwards without stall
    drive(1, 5'd5, 5'd0, 1, 1, {5'd1, 5'd5, 5'd2}, 3'b111, 3'b111, 3'b110);
    chk(stall_req == 1'b0, "R5 load slot1 no stall", DW'(stall_req), '0);
    chk(byp_a == prd_val[DW +: DW], "R5 load slot1 data", byp_a, prd_val[DW +: DW]);
    step_regs("R8");

    // R6 unused source matching a load in slot 0
    drive(1, 5'd10, 5'd11, 0, 1, {5'd1, 5'd2, 5'd10}, 3'b111, 3'b111, 3'b001);
    chk(stall_req == 1'b0, "R6 unused src", DW'(stall_req), '0);
    step_regs("R8");

    // R5/R7 load-use: stall then bubble with held operands
    drive(1, 5'd12, 5'd13, 1, 1, {5'd1, 5'd2, 5'd13}, 3'b111, 3'b111, 3'b001);
    chk(stall_req == 1'b1, "R5 load-use stall", DW'(stall_req), 1);
    step_regs("R7");

    // R10 idle decode
    drive(0, 5'd13, 5'd13, 1, 1, {5'd1, 5'd2, 5'd13}, 3'b111, 3'b111, 3'b001);
    chk(stall_req == 1'b0, "R10 idle no stall", DW'(stall_req), '0);
    step_regs("R10");

    // R1 sweep: every index pattern over four registers
    for (int pass = 0; pass < 2; pass++) begin
      for (int n = 0; n < 1024; n++) begin
        logic [NP*IW-1:0] d;
        d = {IW'((n >> 6) & 3), IW'((n >> 4) & 3), IW'((n >> 2) & 3)};
        drive(($urandom % 8) != 0, IW'(n & 3), IW'((n >> 8) & 3),
              ($urandom % 4) != 0, ($urandom % 4) != 0, d,
              NP'($urandom), NP'($urandom | 3), NP'($urandom));
        check_comb("R1");
        step_regs("R8");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule